// File: doc/BRIEF.md
# Jittered PWM Timing Generator

This block produces the switching-cycle timing for a peak-current-mode power converter controller, running from a fixed system clock. Every switching period opens with a one-clock cycle-start pulse and, when enabled, a gate-on request. The on-time then ends on whichever comes first: a peak-current trip flag or a maximum duty-cycle limit. Two rules bound that on-time. A trip is ignored during a leading-edge blanking window, and once the window has passed the gate still stays on for a minimum number of clocks.

The switching period is not fixed. A triangular sweep walks the period word between a lower and an upper limit in steps of a fixed size. This spreads conducted emission around the nominal rate: about 115 kHz, swept by roughly ±8 kHz at a rate of about 250 Hz when the defaults are used with a 100 MHz clock. All timing values are elaboration parameters counted in system clocks. The surrounding controller supplies the trip flag from its analog comparator and forwards the gate request to the driver.

Top module: `pwm_jitter_gen`

## Requirements
- R1: While reset is high, gate_req, blank and cycle_start are all low. The first cycle_start appears in the clock cycle right after reset is released, and if enable is high gate_req is high in that same cycle.
- R2: cycle_start is high for exactly one clock per switching period. The number of clocks from one cycle_start to the next equals the period word that was latched at the first of the two.
- R3: The period word starts at PERIOD_MAX. It keeps each value for SWEEP_HOLD consecutive periods and then moves by SWEEP_STEP, first downwards. If a step would reach or pass PERIOD_MIN, the word is set to PERIOD_MIN and the direction turns upwards; the upper limit PERIOD_MAX is handled the same way in the other direction. The word never leaves [PERIOD_MIN, PERIOD_MAX].
- R4: gate_req rises only in a cycle where cycle_start is high. The first gate clock of a period counts as on-time clock 0.
- R5: blank is high during on-time clocks 0 to BLANK_CYC-1 while the gate is on. A trip that is high in any of those clocks has no effect on when the gate ends.
- R6: A trip that is high in on-time clock k, where k >= BLANK_CYC and k >= MIN_ON_CYC-1, makes gate_req fall after clock k, so the gate is on for k+1 clocks.
- R7: A trip that arrives after blanking but before the minimum on-time is remembered. The gate then ends after exactly MIN_ON_CYC clocks.
- R8: When no trip arrives, the gate stays on for exactly floor(P*DUTY_PCT/100) clocks, where P is the current period word.
- R9: When enable is low, gate_req is low in the same cycle. A period that is already running does not turn the gate back on even if enable returns. cycle_start and the sweep keep running while enable is low, and the gate turns on again at the first cycle_start that sees enable high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Allows the gate to turn on; low forces the gate off at once |
| trip | input | 1 | Peak-current comparator flag, active high |
| gate_req | output | 1 | Gate-on request to the driver |
| blank | output | 1 | High during the leading-edge blanking window |
| cycle_start | output | 1 | One-clock pulse at the start of every switching period |

## Verification
All outputs come from registers, and gate_req is also gated by enable. A trip that is high in on-time clock k therefore shows up as gate_req low in clock k+1, and a change on enable shows up in gate_req within the same clock. A new period word takes effect at the cycle_start that follows the edge where the period wraps. The bench drives inputs and samples outputs one time step after the falling edge. It counts on-time clocks starting from the sample in which cycle_start is seen, so clock k of the count is the cycle in which a trip driven at that sample is registered. It keeps its own index of periods and from that index computes the expected period word and the expected duty limit for every measured period.

// File: rtl/pwmj_pkg.sv
package pwmj_pkg;

    typedef enum logic {
        SWEEP_DOWN = 1'b0,
        SWEEP_UP   = 1'b1
    } sweep_dir_t;

    typedef struct packed {
        logic active;
        logic tripped;
    } gate_flags_t;

    function automatic int max_on_cycles(input int period, input int pct);
        return (period * pct) / 100;
    endfunction

endpackage

// File: rtl/pwmj_sweep.sv
module pwmj_sweep
    import pwmj_pkg::*;
#(
    parameter int PERIOD_MIN = 813,
    parameter int PERIOD_MAX = 935,
    parameter int SWEEP_STEP = 1,
    parameter int SWEEP_HOLD = 2,
    parameter int PW         = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          advance,
    output logic [PW-1:0] period_word
);
    localparam int HW = (SWEEP_HOLD > 1) ? $clog2(SWEEP_HOLD) : 1;
    localparam logic [HW-1:0] HOLD_LAST = HW'(SWEEP_HOLD - 1);
    localparam logic [PW:0]   STEP_X    = (PW+1)'(SWEEP_STEP);
    localparam logic [PW:0]   LO_X      = (PW+1)'(PERIOD_MIN);
    localparam logic [PW:0]   HI_X      = (PW+1)'(PERIOD_MAX);

    logic [HW-1:0] hold_cnt;
    sweep_dir_t    dir;
    logic [PW:0]   word_x;

    assign word_x = {1'b0, period_word};

    always_ff @(posedge clk) begin
        if (rst) begin
            period_word <= PW'(PERIOD_MAX);
            dir         <= SWEEP_DOWN;
            hold_cnt    <= '0;
        end else if (advance) begin
            if (hold_cnt == HOLD_LAST) begin
                hold_cnt <= '0;
                if (dir == SWEEP_DOWN) begin
                    if (word_x <= LO_X + STEP_X) begin
                        period_word <= PW'(PERIOD_MIN);
                        dir         <= SWEEP_UP;
                    end else begin
                        period_word <= PW'(word_x - STEP_X);
                    end
                end else begin
                    if (word_x + STEP_X >= HI_X) begin
                        period_word <= PW'(PERIOD_MAX);
                        dir         <= SWEEP_DOWN;
                    end else begin
                        period_word <= PW'(word_x + STEP_X);
                    end
                end
            end else begin
                hold_cnt <= hold_cnt + 1'b1;
            end
        end
    end

    assert_word_range_R3: assert property (@(posedge clk) disable iff (rst)
        (word_x >= LO_X) && (word_x <= HI_X));

    assert_word_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(advance) |-> $stable(period_word));

endmodule

// File: rtl/pwmj_phase.sv
module pwmj_phase #(
    parameter int PERIOD_MAX = 935,
    parameter int PW         = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] next_period,
    output logic          wrap,
    output logic          cycle_start
);
    logic [PW-1:0] ph;
    logic [PW-1:0] cur_p;

    assign wrap        = (ph == cur_p - 1'b1);
    assign cycle_start = (ph == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_p <= PW'(PERIOD_MAX);
            ph    <= PW'(PERIOD_MAX - 1);
        end else if (wrap) begin
            cur_p <= next_period;
            ph    <= '0;
        end else begin
            ph <= ph + 1'b1;
        end
    end

    assert_phase_bound_R2: assert property (@(posedge clk) disable iff (rst)
        ph < cur_p);

    assert_start_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        cycle_start |=> !cycle_start);

endmodule

// File: rtl/pwmj_gate.sv
module pwmj_gate
    import pwmj_pkg::*;
#(
    parameter int BLANK_CYC  = 30,
    parameter int MIN_ON_CYC = 40,
    parameter int DUTY_PCT   = 80,
    parameter int PW         = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic          trip,
    input  logic          wrap,
    input  logic [PW-1:0] next_period,
    output logic          gate_req,
    output logic          blank
);
    localparam logic [PW-1:0] BLANK_W   = PW'(BLANK_CYC);
    localparam logic [PW-1:0] MINON_END = PW'(MIN_ON_CYC - 1);

    gate_flags_t   flags;
    logic [PW-1:0] on_cnt;
    logic [PW-1:0] max_on_lat;
    logic          in_blank;
    logic          trip_ok;
    logic          end_on;

    assign in_blank = (on_cnt < BLANK_W);
    assign trip_ok  = trip && !in_blank;
    assign end_on   = ((trip_ok || flags.tripped) && (on_cnt >= MINON_END))
                   || (on_cnt == max_on_lat - 1'b1);

    assign gate_req = flags.active && enable;
    assign blank    = gate_req && in_blank;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags      <= '0;
            on_cnt     <= '0;
            max_on_lat <= '0;
        end else if (wrap) begin
            flags.active  <= enable;
            flags.tripped <= 1'b0;
            on_cnt        <= '0;
            max_on_lat    <= PW'(max_on_cycles(int'(next_period), DUTY_PCT));
        end else if (flags.active) begin
            if (!enable || end_on) begin
                flags.active <= 1'b0;
            end else begin
                on_cnt <= on_cnt + 1'b1;
                if (trip_ok) flags.tripped <= 1'b1;
            end
        end
    end

    assert_duty_cap_R8: assert property (@(posedge clk) disable iff (rst)
        flags.active |-> (on_cnt < max_on_lat));

    assert_blank_ignore_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.tripped) |-> ($past(on_cnt) >= BLANK_W));

    assert_min_on_R7: assert property (@(posedge clk) disable iff (rst)
        ($fell(flags.active) && $past(enable)) |->
            (($past(on_cnt) >= MINON_END) || ($past(on_cnt) + 1'b1 == $past(max_on_lat))));

endmodule

// File: rtl/pwm_jitter_gen.sv
module pwm_jitter_gen #(
    parameter int PERIOD_MIN = 813,
    parameter int PERIOD_MAX = 935,
    parameter int SWEEP_STEP = 1,
    parameter int SWEEP_HOLD = 2,
    parameter int BLANK_CYC  = 30,
    parameter int MIN_ON_CYC = 40,
    parameter int DUTY_PCT   = 80
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic trip,
    output logic gate_req,
    output logic blank,
    output logic cycle_start
);
    localparam int PW = $clog2(PERIOD_MAX + 1);

    logic [PW-1:0] period_word;
    logic          wrap;

    pwmj_sweep #(
        .PERIOD_MIN (PERIOD_MIN),
        .PERIOD_MAX (PERIOD_MAX),
        .SWEEP_STEP (SWEEP_STEP),
        .SWEEP_HOLD (SWEEP_HOLD),
        .PW         (PW)
    ) u_sweep (
        .clk         (clk),
        .rst         (rst),
        .advance     (wrap),
        .period_word (period_word)
    );

    pwmj_phase #(
        .PERIOD_MAX (PERIOD_MAX),
        .PW         (PW)
    ) u_phase (
        .clk         (clk),
        .rst         (rst),
        .next_period (period_word),
        .wrap        (wrap),
        .cycle_start (cycle_start)
    );

    pwmj_gate #(
        .BLANK_CYC  (BLANK_CYC),
        .MIN_ON_CYC (MIN_ON_CYC),
        .DUTY_PCT   (DUTY_PCT),
        .PW         (PW)
    ) u_gate (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .trip        (trip),
        .wrap        (wrap),
        .next_period (period_word),
        .gate_req    (gate_req),
        .blank       (blank)
    );

    assert_gate_rise_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_req) |-> cycle_start);

endmodule

// File: tb/pwm_jitter_gen_bench.sv
module pwm_jitter_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PMIN  = 20;
    localparam int PMAX  = 28;
    localparam int STEP  = 2;
    localparam int HOLD  = 2;
    localparam int BLANK = 3;
    localparam int MINON = 6;
    localparam int DUTY  = 80;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable = 1'b1;
    logic trip = 1'b0;
    logic gate_req, blank, cycle_start;
    int   checks = 0;
    int   errors = 0;
    int   cs_count = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_jitter_gen #(
        .PERIOD_MIN (PMIN), .PERIOD_MAX (PMAX), .SWEEP_STEP (STEP),
        .SWEEP_HOLD (HOLD), .BLANK_CYC (BLANK), .MIN_ON_CYC (MINON),
        .DUTY_PCT (DUTY)
    ) u_pwm_jitter_gen (
        .clk (clk), .rst (rst), .enable (enable), .trip (trip),
        .gate_req (gate_req), .blank (blank), .cycle_start (cycle_start)
    );

    always @(posedge clk) begin
        if (rst) cs_count <= 0;
        else if (cycle_start) cs_count <= cs_count + 1;
    end

    function automatic int exp_period(input int idx);
        int w = PMAX;
        bit up = 1'b0;
        int h = 0;
        for (int i = 0; i < idx; i++) begin
            if (h == HOLD - 1) begin
                h = 0;
                if (!up) begin
                    if (w <= PMIN + STEP) begin w = PMIN; up = 1'b1; end
                    else w = w - STEP;
                end else begin
                    if (w + STEP >= PMAX) begin w = PMAX; up = 1'b0; end
                    else w = w + STEP;
                end
            end else begin
                h = h + 1;
            end
        end
        return w;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_cs();
        for (int i = 0; i < 64 && !cycle_start; i++) step();
    endtask

    // one full period; trip pulsed in on-time clock trip_at (-1: none)
    task automatic run_period(input string req, input int trip_at, input int exp_on);
        int idx, p, on_n, blank_n;
        wait_cs();
        idx = cs_count;
        p = exp_period(idx);
        on_n = 0;
        blank_n = 0;
        chk("R4", "gate at cycle start", int'(gate_req), 1);
        for (int k = 0; k < p; k++) begin
            if (k > 0) step();
            on_n += int'(gate_req);
            blank_n += int'(blank);
            trip = (k == trip_at);
        end
        trip = 1'b0;
        chk(req, "gate on-clocks", on_n, exp_on);
        chk("R5", "blank clocks", blank_n, BLANK);
        step();
        chk("R2", "cycle_start after period", int'(cycle_start), 1);
    endtask

    task automatic test_reset();
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R1", "outputs in reset", {gate_req, blank, cycle_start}, 0);
        end
        rst = 1'b0;
        step();
        chk("R1", "first cycle_start", int'(cycle_start), 1);
        chk("R1", "first gate", int'(gate_req), 1);
    endtask

    task automatic test_sweep();
        for (int n = 0; n < 20; n++) begin
            int idx, len;
            wait_cs();
            idx = cs_count;
            len = 0;
            do begin
                step();
                len++;
            end while (!cycle_start && len < 64);
            chk("R3", "period length", len, exp_period(idx));
        end
    endtask

    task automatic test_enable();
        int idx, on_n;
        wait_cs();
        idx = cs_count;
        on_n = 0;
        for (int k = 0; k < exp_period(idx); k++) begin
            if (k > 0) step();
            if (k == 5) begin
                enable = 1'b0;
                #1;
                chk("R9", "gate drops with enable", int'(gate_req), 0);
            end
            if (k == 7) enable = 1'b1;
            on_n += int'(gate_req);
        end
        chk("R9", "gate clocks after abort", on_n, 5);
        step();
        chk("R9", "next start gate", {31'd0, cycle_start} + {30'd0, gate_req, 1'b0}, 3);
        // disabled across a whole period start
        enable = 1'b0;
        step();
        wait_cs();
        idx = cs_count;
        chk("R9", "cycle_start while disabled", int'(cycle_start), 1);
        chk("R9", "gate while disabled", int'(gate_req), 0);
        for (int k = 1; k < exp_period(idx); k++) step();
        step();
        chk("R9", "sweep keeps running", int'(cycle_start), 1);
        enable = 1'b1;
        step();
        wait_cs();
        chk("R9", "gate resumes", int'(gate_req), 1);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        test_reset();
        run_period("R8", -1, (exp_period(0) * DUTY) / 100);
        test_sweep();
        run_period("R5", 1, (exp_period(cs_count) * DUTY) / 100);
        run_period("R7", 4, MINON);
        run_period("R6", 9, 10);
        run_period("R6", MINON - 1, MINON);
        test_enable();
        run_period("R8", -1, (exp_period(cs_count) * DUTY) / 100);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule